// File: doc/BRIEF.md
# Multi-Processor Interrupt Mask Dispatcher

This block collects 64 level-sensitive interrupt request lines and hands them to up to four processors. Each processor owns a 64-bit enable mask. A processor is offered only the requests that are pending, enabled in its own mask, and not already in service on that processor. Out of that set, the block picks the source with the largest number. It presents that source as a 12-bit vector together with an interrupt line.

Software writes and reads the masks through a small register port. A processor that is flagged absent cannot have its mask written and never raises its interrupt line. Source 55 carries the cascaded legacy controller. Only the boot processor may take it: the boot processor's bit 55 is always set, and bit 55 of every other processor is always clear.

A per-processor acknowledge pulse puts the presented source in service. A per-processor end-of-interrupt pulse, which names a source number, takes that source out of service again. Sources 59 to 63 are the system error sources, and they have no special handling.

Top module: `mcpu_irq_router`

## Requirements
- R1: `irq_o[c]` is high exactly when some source s has `irq_req_i[s]`=1, mask bit s of processor c is 1, s is not in service on c, and processor c is present.
- R2: Among the sources that qualify for a processor, the highest-numbered source is presented. Source 63 has the highest priority and source 0 the lowest, and the error sources 59 to 63 are ranked in the same way.
- R3: Processor c's vector is `vec_o[12c+11:12c]`. It equals 0x900 + 16·s for the presented source s, and it is 0 while `irq_o[c]` is low.
- R4: A mask write stores bit 55 as 0 for any processor other than the boot processor and as 1 for the boot processor, whatever the written data holds. As a result, source 55 reaches only the boot processor.
- R5: A write aimed at a processor whose `cpu_present_i` bit is 0 leaves that processor's mask unchanged, and that processor's `irq_o` stays low.
- R6: `rst_n` is synchronous and active low. At the last clock edge with `rst_n` low, the block samples `boot_cpu_i`, clears every mask except bit 55 of the boot processor, and clears all in-service state.
- R7: `reg_rdata_o` combinationally returns the stored mask of the processor selected by `reg_addr_i`. A write takes effect at the clock edge where `reg_we_i` is high.
- R8: If `ack_i[c]` is high at an edge while `irq_o[c]` is high, the presented source becomes in service on processor c and is skipped from the next cycle on. If `ack_i[c]` is high while `irq_o[c]` is low, it has no effect.
- R9: If `eoi_i[c]` is high at an edge, source `eoi_src_i[6c+5:6c]` leaves service on processor c. An acknowledge and an end-of-interrupt on the same processor in the same cycle both take effect. If both name the same source, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_cpu_i | input | 2 | Boot processor index, sampled during reset |
| cpu_present_i | input | 4 | Presence flag per processor |
| irq_req_i | input | 64 | Level interrupt requests, one per source |
| reg_we_i | input | 1 | Mask write strobe |
| reg_addr_i | input | 2 | Processor whose mask is written or read |
| reg_wdata_i | input | 64 | Mask write data |
| reg_rdata_o | output | 64 | Stored mask of the addressed processor |
| ack_i | input | 4 | Acknowledge pulse per processor |
| eoi_i | input | 4 | End-of-interrupt pulse per processor |
| eoi_src_i | input | 24 | Source number retired per processor, 6 bits each |
| irq_o | output | 4 | Interrupt line per processor |
| vec_o | output | 48 | Presented vector per processor, 12 bits each |

## Verification
On one processor, the acknowledge that marks a source in service and the end-of-interrupt that releases one can arrive in the same cycle. The bench pulses both together in two cases. In the first case they name different sources: it checks that the released source comes back as the presented vector while the newly acknowledged one is hidden. In the second case both name the source being presented: it checks that this source stays in service, so the interrupt line drops.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int unsigned IRQD_SRC_DEF  = 64;
    localparam int unsigned IRQD_CPU_DEF  = 4;
    localparam int unsigned IRQD_VEC_W    = 12;
    localparam int unsigned IRQD_STRIDE_SH = 4;
    localparam logic [IRQD_VEC_W-1:0] IRQD_VEC_BASE = 12'h900;
    localparam int unsigned IRQD_CASCADE_DEF = 55;
endpackage

// File: rtl/irqd_prio_enc.sv
module irqd_prio_enc #(
    parameter int unsigned N     = 64,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    // Ascending scan: the last set bit seen is the highest-numbered one.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqd_cpu_slice.sv
module irqd_cpu_slice
    import irqd_pkg::*;
#(
    parameter int unsigned NUM_SRC  = IRQD_SRC_DEF,
    parameter int unsigned VEC_W    = IRQD_VEC_W,
    parameter int unsigned STRIDE_SH = IRQD_STRIDE_SH,
    parameter logic [VEC_W-1:0] VEC_BASE = IRQD_VEC_BASE,
    localparam int unsigned SRC_IDX_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]   req_i,
    input  logic [NUM_SRC-1:0]   mask_i,
    input  logic [NUM_SRC-1:0]   insvc_i,
    input  logic                 present_i,
    output logic                 irq_o,
    output logic [SRC_IDX_W-1:0] src_o,
    output logic [VEC_W-1:0]     vec_o
);
    logic [NUM_SRC-1:0] eligible;
    logic               hit;

    assign eligible = present_i ? (req_i & mask_i & ~insvc_i) : '0;

    irqd_prio_enc #(.N(NUM_SRC)) u_prio (
        .req_i (eligible),
        .hit_o (hit),
        .idx_o (src_o)
    );

    assign irq_o = hit;
    assign vec_o = hit ? (VEC_BASE + (VEC_W'(src_o) << STRIDE_SH)) : '0;
endmodule

// File: rtl/mcpu_irq_router.sv
module mcpu_irq_router
    import irqd_pkg::*;
#(
    parameter int unsigned NUM_SRC     = IRQD_SRC_DEF,
    parameter int unsigned NUM_CPU     = IRQD_CPU_DEF,
    parameter int unsigned CASCADE_SRC = IRQD_CASCADE_DEF,
    localparam int unsigned VEC_W     = IRQD_VEC_W,
    localparam int unsigned SRC_IDX_W = $clog2(NUM_SRC),
    localparam int unsigned CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CPU_IDX_W-1:0]           boot_cpu_i,
    input  logic [NUM_CPU-1:0]             cpu_present_i,
    input  logic [NUM_SRC-1:0]             irq_req_i,
    input  logic                           reg_we_i,
    input  logic [CPU_IDX_W-1:0]           reg_addr_i,
    input  logic [NUM_SRC-1:0]             reg_wdata_i,
    output logic [NUM_SRC-1:0]             reg_rdata_o,
    input  logic [NUM_CPU-1:0]             ack_i,
    input  logic [NUM_CPU-1:0]             eoi_i,
    input  logic [NUM_CPU*SRC_IDX_W-1:0]   eoi_src_i,
    output logic [NUM_CPU-1:0]             irq_o,
    output logic [NUM_CPU*VEC_W-1:0]       vec_o
);
    localparam logic [NUM_SRC-1:0] CASCADE_BIT = NUM_SRC'(1) << CASCADE_SRC;
    localparam logic [VEC_W-1:0] VEC_TOP =
        IRQD_VEC_BASE + (VEC_W'(NUM_SRC - 1) << IRQD_STRIDE_SH);
    localparam logic [VEC_W-1:0] VEC_CASCADE =
        IRQD_VEC_BASE + (VEC_W'(CASCADE_SRC) << IRQD_STRIDE_SH);

    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_SRC-1:0] mask;
        logic [NUM_CPU-1:0][NUM_SRC-1:0] insvc;
        logic [CPU_IDX_W-1:0]            boot;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_CPU-1:0][SRC_IDX_W-1:0] sel_src;
    logic [NUM_CPU-1:0][SRC_IDX_W-1:0] eoi_src;

    // Per-processor selection slices
    for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_cpu
        assign eoi_src[c] = eoi_src_i[c*SRC_IDX_W +: SRC_IDX_W];

        irqd_cpu_slice #(.NUM_SRC(NUM_SRC)) u_slice (
            .req_i     (irq_req_i),
            .mask_i    (state_q.mask[c]),
            .insvc_i   (state_q.insvc[c]),
            .present_i (cpu_present_i[c]),
            .irq_o     (irq_o[c]),
            .src_o     (sel_src[c]),
            .vec_o     (vec_o[c*VEC_W +: VEC_W])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (reg_we_i && cpu_present_i[reg_addr_i]) begin
            if (reg_addr_i == state_q.boot)
                state_d.mask[reg_addr_i] = reg_wdata_i | CASCADE_BIT;
            else
                state_d.mask[reg_addr_i] = reg_wdata_i & ~CASCADE_BIT;
        end
        for (int c = 0; c < int'(NUM_CPU); c++) begin
            // Release first so a same-source acknowledge wins.
            if (eoi_i[c])
                state_d.insvc[c][eoi_src[c]] = 1'b0;
            if (ack_i[c] && irq_o[c])
                state_d.insvc[c][sel_src[c]] = 1'b1;
        end
        if (!rst_n) begin
            state_d.boot  = boot_cpu_i;
            state_d.mask  = '0;
            state_d.insvc = '0;
            state_d.mask[boot_cpu_i] = CASCADE_BIT;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign reg_rdata_o = state_q.mask[reg_addr_i];

    // Global checks
    p_boot_cascade_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.mask[state_q.boot][CASCADE_SRC])
        else $error("boot processor lost cascade enable");

    p_absent_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && !cpu_present_i[reg_addr_i]) |=> $stable(state_q.mask))
        else $error("write to absent processor changed a mask");

    // Per-processor checks
    for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_chk
        p_absent_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_present_i[c] |-> !irq_o[c])
            else $error("absent processor interrupted");

        p_vec_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (vec_o[c*VEC_W +: 4] == 4'h0
                          && vec_o[c*VEC_W +: VEC_W] >= IRQD_VEC_BASE
                          && vec_o[c*VEC_W +: VEC_W] <= VEC_TOP))
            else $error("vector off grid");

        p_cascade_boot_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[c] && CPU_IDX_W'(c) != state_q.boot)
                |-> vec_o[c*VEC_W +: VEC_W] != VEC_CASCADE)
            else $error("cascade source reached non-boot processor");

        p_insvc_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> !state_q.insvc[c][sel_src[c]])
            else $error("in-service source presented");

        p_ack_records_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[c] && irq_o[c]) |=> state_q.insvc[c][$past(sel_src[c])])
            else $error("acknowledge not recorded");

        p_eoi_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_i[c] && !(ack_i[c] && irq_o[c] && sel_src[c] == eoi_src[c]))
                |=> !state_q.insvc[c][$past(eoi_src[c])])
            else $error("end-of-interrupt not applied");
    end
endmodule

// File: tb/mcpu_irq_router_tb.sv
module mcpu_irq_router_tb_top;
    localparam logic [63:0] B55 = 64'h0080_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  boot_cpu_i;
    logic [3:0]  cpu_present_i;
    logic [63:0] irq_req_i;
    logic        reg_we_i;
    logic [1:0]  reg_addr_i;
    logic [63:0] reg_wdata_i;
    logic [63:0] reg_rdata_o;
    logic [3:0]  ack_i, eoi_i;
    logic [23:0] eoi_src_i;
    logic [3:0]  irq_o;
    logic [47:0] vec_o;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mcpu_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .boot_cpu_i(boot_cpu_i),
        .cpu_present_i(cpu_present_i), .irq_req_i(irq_req_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .ack_i(ack_i), .eoi_i(eoi_i), .eoi_src_i(eoi_src_i),
        .irq_o(irq_o), .vec_o(vec_o)
    );

    function automatic logic [63:0] ev(input int n);
        return 64'(12'h900 + n * 16);
    endfunction

    function automatic logic [63:0] vec(input int c);
        return 64'(vec_o[c*12 +: 12]);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] boot, input logic [3:0] pres);
        rst_n = 1'b0; boot_cpu_i = boot; cpu_present_i = pres;
        irq_req_i = '0; reg_we_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
        ack_i = '0; eoi_i = '0; eoi_src_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wr(input logic [1:0] cpu, input logic [63:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = cpu; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] cpu, output logic [63:0] d);
        reg_addr_i = cpu;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic pulse(input logic [3:0] a, input logic [3:0] e, input logic [23:0] es);
        @(negedge clk);
        ack_i = a; eoi_i = e; eoi_src_i = es;
        @(negedge clk);
        ack_i = '0; eoi_i = '0;
        #1;
    endtask

    task automatic t_reset_state();
        logic [63:0] d;
        do_reset(2'd1, 4'b0111);
        rd(2'd0, d); chk("R6 cpu0 mask", d, 64'h0);
        rd(2'd1, d); chk("R6 boot mask", d, B55);
        rd(2'd2, d); chk("R6 cpu2 mask", d, 64'h0);
        chk("R1 idle irq", 64'(irq_o), 64'h0);
        chk("R3 idle vec", 64'(vec_o), 64'h0);
    endtask

    task automatic t_mask_regs();
        logic [63:0] d;
        wr(2'd0, '1);
        rd(2'd0, d); chk("R4 non-boot bit55 dropped", d, ~B55);
        wr(2'd1, 64'h0);
        rd(2'd1, d); chk("R4 boot bit55 kept", d, B55);
        wr(2'd2, 64'h0000_0000_F0F0_1234);
        rd(2'd2, d); chk("R7 readback", d, 64'h0000_0000_F0F0_1234);
        wr(2'd3, '1);
        rd(2'd3, d); chk("R5 absent write discarded", d, 64'h0);
        wr(2'd2, 64'h0);
    endtask

    task automatic t_priority();
        irq_req_i = (64'h1 << 3) | (64'h1 << 40);
        #1;
        chk("R1 cpu0 irq", 64'(irq_o[0]), 64'h1);
        chk("R2 cpu0 picks 40", vec(0), ev(40));
        chk("R1 cpu2 masked off", 64'(irq_o[2]), 64'h0);
        chk("R3 masked cpu vec zero", vec(2), 64'h0);
        irq_req_i = B55;
        #1;
        chk("R4 cascade to boot", vec(1), ev(55));
        chk("R4 cascade not to cpu0", 64'(irq_o[0]), 64'h0);
        irq_req_i = (64'h1 << 63) | (64'h1 << 59) | B55 | 64'h1;
        #1;
        chk("R2 error source 63 first", vec(0), ev(63));
        irq_req_i = (64'h1 << 59) | 64'h1;
        #1;
        chk("R2 error source 59 over 0", vec(0), ev(59));
        irq_req_i = 64'h1;
        #1;
        chk("R3 source 0 vector", vec(0), 64'h900);
        irq_req_i = '1;
        #1;
        chk("R5 absent cpu quiet", 64'(irq_o[3]), 64'h0);
    endtask

    task automatic t_ack_eoi();
        irq_req_i = (64'h1 << 3) | (64'h1 << 40);
        pulse(4'b0001, 4'b0000, 24'h0);
        chk("R8 ack hides 40", vec(0), ev(3));
        pulse(4'b0001, 4'b0000, 24'h0);
        chk("R8 all in service", 64'(irq_o[0]), 64'h0);
        pulse(4'b0000, 4'b0001, 24'd40);
        chk("R9 eoi restores 40", vec(0), ev(40));
        pulse(4'b0100, 4'b0000, 24'h0);
        wr(2'd2, 64'h1 << 40);
        chk("R8 ack while idle ignored", vec(2), ev(40));
    endtask

    task automatic t_same_cycle();
        pulse(4'b0001, 4'b0001, 24'd3);
        chk("R9 ack+eoi different sources", vec(0), ev(3));
        pulse(4'b0001, 4'b0001, 24'd3);
        chk("R9 ack wins same source", 64'(irq_o[0]), 64'h0);
        pulse(4'b0000, 4'b0001, 24'd40);
        chk("R9 release after collision", vec(0), ev(40));
    endtask

    task automatic t_boot_resample();
        logic [63:0] d;
        do_reset(2'd2, 4'b0111);
        rd(2'd2, d); chk("R6 new boot mask", d, B55);
        rd(2'd1, d); chk("R6 old boot cleared", d, 64'h0);
        irq_req_i = B55;
        #1;
        chk("R4 cascade follows boot", 64'(irq_o), 64'h4);
        chk("R6 in-service cleared", 64'(irq_o[0]), 64'h0);
    endtask

    initial begin
        t_reset_state();
        t_mask_regs();
        t_priority();
        t_ack_eoi();
        t_same_cycle();
        t_boot_resample();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule